// File: doc/BRIEF.md
# Two-Thread Instruction-Count Fetch Arbiter

This block decides, on every cycle, which of two simultaneous hardware threads may fetch into a shared out-of-order front end. For each thread it keeps a count of instructions in flight. The count rises by one on each fetch grant, falls by a retire or squash amount supplied at the ports, and never drops below zero. Among the threads that may fetch, the one with the fewest instructions in flight wins, so a thread that drains its work slowly cannot crowd the shared queue.

Each thread has a signed priority bias. A thread's bias is added to the other thread's count before the two counts are compared, so a positive bias favours its own thread. While both threads are active, each one is capped below the full queue depth. A lone active thread may fill the whole queue. A thread can also park itself on a memory line. It then takes no fetch slots until a write to that 64-byte line is seen, which keeps a spinning thread from burning fetch bandwidth.

The grant and thread ID are combinational from the registered state and the current inputs. The counters, the sleep state and the tie-break history change at the clock edge.

Top module: `smt_icount_arb`

## Requirements
- R1: After reset both counts are zero, no thread is asleep, and the first tie goes to thread 0 (the last-granted history resets to thread 1).
- R2: If both threads are eligible and their effective counts differ, the thread with the lower effective count is granted in the same cycle.
- R3: If both threads are eligible and their effective counts are equal, the thread that did not receive the most recent grant is granted.
- R4: The effective count of thread 0 is its in-flight count plus `prio_bias1` as a signed value, and thread 1's is its count plus `prio_bias0`. Both biases are 5-bit two's complement.
- R5: At each edge a thread's count becomes max(0, count + granted - retire amount), where granted is 1 if that thread was granted in the cycle.
- R6: While `thr_active` is 2'b11, a thread whose count is 24 or more is not eligible.
- R7: While only one bit of `thr_active` is set, the active thread stays eligible up to a count of 31, so it can reach 32. A thread whose `thr_active` bit is 0 is never granted.
- R8: A thread with its `park_req` bit high at an edge is asleep from the next cycle, and a sleeping thread is never granted. In the cycle of `park_req` itself, eligibility is unchanged.
- R9: A sleeping thread wakes at the edge of a cycle in which `mem_wr_vld` is high and `mem_wr_addr` equals its parked address in all bits above bit 5. It is eligible from the next cycle. A write to another line has no effect. If a park and a wake occur in the same cycle, the park wins.
- R10: A thread is eligible only if its `fetch_req` bit is high and it is active, awake and under its cap. If no thread is eligible, `fetch_grant` is 0 and `fetch_tid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | 2 | Bit t set: thread t holds a software thread |
| fetch_req | input | 2 | Bit t set: thread t has a fetch ready |
| retire_cnt0 | input | 6 | Instructions of thread 0 leaving this cycle (retire or squash) |
| retire_cnt1 | input | 6 | Instructions of thread 1 leaving this cycle |
| prio_bias0 | input | 5 | Signed bias favouring thread 0, added to thread 1's count |
| prio_bias1 | input | 5 | Signed bias favouring thread 1, added to thread 0's count |
| park_req | input | 2 | Bit t set: thread t goes to sleep on park_addr t |
| park_addr0 | input | 16 | Byte address watched by thread 0 |
| park_addr1 | input | 16 | Byte address watched by thread 1 |
| mem_wr_vld | input | 1 | A memory write is observed this cycle |
| mem_wr_addr | input | 16 | Byte address of the observed write |
| fetch_grant | output | 1 | A thread fetches this cycle |
| fetch_tid | output | 1 | Thread granted (0 when no grant) |

## Verification
`fetch_grant` and `fetch_tid` are due in the same cycle as the inputs that select them. Any effect of a grant, retire, park or matching write on the counts or the sleep state shows up one clock edge later. The bench drives every input just after the falling edge. It compares both outputs one nanosecond later, against a model that is stepped once per cycle. It then advances the model's counts, sleep flags and tie history at the rising edge. In this way the effect of each stimulus is checked in exactly the cycle that follows it. Directed phases cover the cap in two-thread mode, the full depth in single-thread mode, the saturating retire, the biases, tie alternation and park/wake on exact and neighbouring lines. A long pseudo-random sweep then mixes all inputs.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;
    localparam int NUM_THR = 2;
    typedef logic tid_t;

    // tie-break: hand the slot to the thread that did not win last time
    function automatic tid_t tie_winner(input tid_t last_tid);
        return ~last_tid;
    endfunction
endpackage

// File: rtl/smt_inflight_ctr.sv
module smt_inflight_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic [CW-1:0] dec,
    output logic [CW-1:0] cnt
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic [CW:0] sum;
    logic [CW:0] diff;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + {{CW{1'b0}}, inc};
        diff = sum - {1'b0, dec};
        if ({1'b0, dec} >= sum) st_d.cnt = '0;
        else                    st_d.cnt = diff[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/smt_quiesce_mon.sv
module smt_quiesce_mon #(
    parameter int AW = 16,
    parameter int LB = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          park,
    input  logic [AW-1:0] park_addr,
    input  logic          wr_vld,
    input  logic [AW-1:0] wr_addr,
    output logic          asleep
);
    typedef struct packed {
        logic          asleep;
        logic [AW-1:0] watch;
    } mon_st_t;

    mon_st_t     st_d, st_q;
    logic [AW-1:0] delta;
    logic          line_hit;

    always_comb begin
        st_d     = st_q;
        delta    = st_q.watch ^ wr_addr;
        line_hit = ((delta >> LB) == '0);
        if (park) begin
            st_d.asleep = 1'b1;
            st_d.watch  = park_addr;
        end else if (st_q.asleep && wr_vld && line_hit) begin
            st_d.asleep = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign asleep = st_q.asleep;
endmodule

// File: rtl/smt_pick.sv
module smt_pick #(
    parameter int EW = 8
) (
    input  logic                 [1:0]  elig,
    input  logic signed          [EW-1:0] eff0,
    input  logic signed          [EW-1:0] eff1,
    input  smt_fetch_pkg::tid_t         last_tid,
    output logic                        grant,
    output smt_fetch_pkg::tid_t         tid
);
    always_comb begin
        grant = |elig;
        tid   = 1'b0;
        unique case (elig)
            2'b01:   tid = 1'b0;
            2'b10:   tid = 1'b1;
            2'b11: begin
                if (eff0 < eff1)      tid = 1'b0;
                else if (eff1 < eff0) tid = 1'b1;
                else                  tid = smt_fetch_pkg::tie_winner(last_tid);
            end
            default: tid = 1'b0;
        endcase
    end
endmodule

// File: rtl/smt_icount_arb.sv
module smt_icount_arb #(
    parameter int QUEUE_DEPTH = 32,
    parameter int SHARE_CAP   = 24,
    parameter int BIAS_W      = 5,
    parameter int ADDR_W      = 16,
    parameter int LINE_BYTES  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               thr_active,
    input  logic [1:0]               fetch_req,
    input  logic [$clog2(QUEUE_DEPTH+1)-1:0] retire_cnt0,
    input  logic [$clog2(QUEUE_DEPTH+1)-1:0] retire_cnt1,
    input  logic signed [BIAS_W-1:0] prio_bias0,
    input  logic signed [BIAS_W-1:0] prio_bias1,
    input  logic [1:0]               park_req,
    input  logic [ADDR_W-1:0]        park_addr0,
    input  logic [ADDR_W-1:0]        park_addr1,
    input  logic                     mem_wr_vld,
    input  logic [ADDR_W-1:0]        mem_wr_addr,
    output logic                     fetch_grant,
    output logic                     fetch_tid
);
    import smt_fetch_pkg::*;

    localparam int CW = $clog2(QUEUE_DEPTH + 1);
    localparam int LB = $clog2(LINE_BYTES);
    localparam int EW = ((CW > BIAS_W) ? CW : BIAS_W) + 2;
    localparam logic [CW-1:0] CAP_SHARED = CW'(SHARE_CAP);
    localparam logic [CW-1:0] CAP_ALONE  = CW'(QUEUE_DEPTH);

    typedef struct packed {
        tid_t last_tid;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [CW-1:0]            cnt    [NUM_THR];
    logic [CW-1:0]            retire [NUM_THR];
    logic signed [BIAS_W-1:0] bias   [NUM_THR];
    logic [ADDR_W-1:0]        paddr  [NUM_THR];
    logic signed [EW-1:0]     eff    [NUM_THR];
    logic [NUM_THR-1:0]       asleep;
    logic [NUM_THR-1:0]       elig;
    logic [CW-1:0]            cap;
    logic                     grant;
    tid_t                     tid;

    assign retire[0] = retire_cnt0;
    assign retire[1] = retire_cnt1;
    assign bias[0]   = prio_bias0;
    assign bias[1]   = prio_bias1;
    assign paddr[0]  = park_addr0;
    assign paddr[1]  = park_addr1;

    assign cap = (&thr_active) ? CAP_SHARED : CAP_ALONE;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        smt_inflight_ctr #(.CW(CW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (grant && (tid == tid_t'(t))),
            .dec   (retire[t]),
            .cnt   (cnt[t])
        );

        smt_quiesce_mon #(.AW(ADDR_W), .LB(LB)) u_mon (
            .clk       (clk),
            .rst_n     (rst_n),
            .park      (park_req[t]),
            .park_addr (paddr[t]),
            .wr_vld    (mem_wr_vld),
            .wr_addr   (mem_wr_addr),
            .asleep    (asleep[t])
        );

        // bias of the other thread is added to this thread's count
        assign eff[t] = $signed({{(EW-CW){1'b0}}, cnt[t]})
                      + $signed({{(EW-BIAS_W){bias[1-t][BIAS_W-1]}}, bias[1-t]});

        assign elig[t] = fetch_req[t] & thr_active[t] & ~asleep[t] & (cnt[t] < cap);
    end

    smt_pick #(.EW(EW)) u_pick (
        .elig     (elig),
        .eff0     (eff[0]),
        .eff1     (eff[1]),
        .last_tid (st_q.last_tid),
        .grant    (grant),
        .tid      (tid)
    );

    always_comb begin
        st_d = st_q;
        if (grant) st_d.last_tid = tid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{last_tid: 1'b1};
        else        st_q <= st_d;
    end

    assign fetch_grant = grant;
    assign fetch_tid   = tid;
endmodule

// File: rtl/smt_icount_arb_chk.sv
module smt_icount_arb_chk #(
    parameter int QUEUE_DEPTH = 32,
    parameter int SHARE_CAP   = 24,
    parameter int CW          = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    thr_active,
    input logic [1:0]    fetch_req,
    input logic [1:0]    park_req,
    input logic          fetch_grant,
    input logic          fetch_tid,
    input logic [CW-1:0] cnt0,
    input logic [CW-1:0] cnt1
);
    a_r10_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |-> (fetch_req[fetch_tid] && thr_active[fetch_tid]));

    a_r10_quiet_tid: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_grant |-> (fetch_tid == 1'b0));

    a_r8_park_blocks0: assert property (@(posedge clk) disable iff (!rst_n)
        park_req[0] |=> !(fetch_grant && fetch_tid == 1'b0));

    a_r8_park_blocks1: assert property (@(posedge clk) disable iff (!rst_n)
        park_req[1] |=> !(fetch_grant && fetch_tid == 1'b1));

    a_r6_cap0: assert property (@(posedge clk) disable iff (!rst_n)
        ((&thr_active) && cnt0 >= CW'(SHARE_CAP)) |-> !(fetch_grant && fetch_tid == 1'b0));

    a_r6_cap1: assert property (@(posedge clk) disable iff (!rst_n)
        ((&thr_active) && cnt1 >= CW'(SHARE_CAP)) |-> !(fetch_grant && fetch_tid == 1'b1));

    a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0 <= CW'(QUEUE_DEPTH)) && (cnt1 <= CW'(QUEUE_DEPTH)));
endmodule

bind smt_icount_arb smt_icount_arb_chk #(
    .QUEUE_DEPTH (QUEUE_DEPTH),
    .SHARE_CAP   (SHARE_CAP),
    .CW          (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .thr_active  (thr_active),
    .fetch_req   (fetch_req),
    .park_req    (park_req),
    .fetch_grant (fetch_grant),
    .fetch_tid   (fetch_tid),
    .cnt0        (cnt[0]),
    .cnt1        (cnt[1])
);

// File: tb/tb_smt_icount_arb.sv
module tb_smt_icount_arb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        act = '0, req = '0, park = '0;
    logic [5:0]        r0 = '0, r1 = '0;
    logic signed [4:0] b0 = '0, b1 = '0;
    logic [15:0]       pa0 = '0, pa1 = '0, wa = '0;
    logic              wv = 1'b0;
    logic              g;
    logic              tid;

    int n_chk = 0, n_fail = 0;
    int mc [2];
    bit ms [2];
    int mw [2];
    bit mlast;
    bit done = 0;
    int rs = 32'h1234_5678;

    always #2 clk = ~clk;

    smt_icount_arb dut (
        .clk(clk), .rst_n(rst_n), .thr_active(act), .fetch_req(req),
        .retire_cnt0(r0), .retire_cnt1(r1), .prio_bias0(b0), .prio_bias1(b1),
        .park_req(park), .park_addr0(pa0), .park_addr1(pa1),
        .mem_wr_vld(wv), .mem_wr_addr(wa), .fetch_grant(g), .fetch_tid(tid)
    );

    function automatic int rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >>> 17);
        rs = rs ^ (rs << 5);
        return rs & 32'h7fff_ffff;
    endfunction

    // One cycle: inputs already set after negedge; check, update model, advance.
    task automatic cyc(input string tag);
        int cap, e0, e1, ret, nx;
        bit el [2];
        bit eg, et;
        #1;
        cap = (act == 2'b11) ? 24 : 32;
        for (int t = 0; t < 2; t++)
            el[t] = req[t] && act[t] && !ms[t] && (mc[t] < cap);
        e0 = mc[0] + int'(b1);
        e1 = mc[1] + int'(b0);
        eg = el[0] || el[1];
        et = 1'b0;
        if (el[0] && el[1]) et = (e0 < e1) ? 1'b0 : (e1 < e0) ? 1'b1 : !mlast;
        else if (el[1]) et = 1'b1;
        n_chk++;
        if (g !== eg || tid !== et) begin
            n_fail++;
            $display("FAIL %s: grant/tid actual=%0b/%0b expected=%0b/%0b at %0t",
                     tag, g, tid, eg, et, $time);
        end
        for (int t = 0; t < 2; t++) begin
            ret = (t == 0) ? int'(r0) : int'(r1);
            nx  = mc[t] + ((eg && et == t) ? 1 : 0) - ret;
            mc[t] = (nx < 0) ? 0 : nx;
            if (park[t]) begin
                ms[t] = 1;
                mw[t] = ((t == 0) ? int'(pa0) : int'(pa1)) >> 6;
            end else if (ms[t] && wv && (int'(wa) >> 6) == mw[t]) begin
                ms[t] = 0;
            end
        end
        if (eg) mlast = et;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        mc[0] = 0; mc[1] = 0; ms[0] = 0; ms[1] = 0; mw[0] = 0; mw[1] = 0; mlast = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R10: reset state, nothing requested
        act = 2'b11; req = 2'b00;
        cyc("R1 idle after reset");
        req = 2'b11;
        cyc("R1 first tie to thread 0");

        // R3 / R6: fill both threads equally until the shared cap
        for (int i = 0; i < 50; i++) cyc("R3 R6 alternate to cap");
        cyc("R6 both capped no grant");

        // R5: retire some from thread 0, then saturate at zero
        r0 = 6'd5; cyc("R5 retire 5");
        r0 = 6'd0; cyc("R5 refetch after retire");
        r0 = 6'd40; r1 = 6'd40; cyc("R5 retire floors at zero");
        r0 = 6'd0; r1 = 6'd0; req = 2'b00; cyc("R5 idle after floor");

        // R7: only thread 0 active, fills to full depth; thread 1 ignored
        act = 2'b01; req = 2'b11;
        for (int i = 0; i < 34; i++) cyc("R7 single thread full depth");
        act = 2'b11; cyc("R6 two-thread cap re-applied");
        r0 = 6'd32; req = 2'b00; cyc("R5 drain");
        r0 = 6'd0; r1 = 6'd32; cyc("R5 drain");
        r1 = 6'd0;

        // R4 / R2: biases skew the pick
        req = 2'b11;
        b0 = 5'sd3; b1 = 5'sd0;
        for (int i = 0; i < 12; i++) cyc("R4 positive bias for thread 0");
        b0 = -5'sd4; b1 = 5'sd2;
        for (int i = 0; i < 12; i++) cyc("R4 negative bias");
        b0 = 5'sd0; b1 = 5'sd0;
        r1 = 6'd3; for (int i = 0; i < 6; i++) cyc("R2 fewest in flight wins");
        r1 = 6'd0; r0 = 6'd32; r1 = 6'd32; req = 2'b00; cyc("R5 drain");
        r0 = 6'd0; r1 = 6'd0;

        // R8 / R9: park thread 1 on line 0x1200
        req = 2'b10; pa1 = 16'h1234; park = 2'b10;
        cyc("R8 park cycle still eligible");
        park = 2'b00;
        for (int i = 0; i < 3; i++) cyc("R8 asleep no grant");
        wv = 1'b1; wa = 16'h1240; cyc("R9 other line ignored");
        wv = 1'b0; cyc("R9 still asleep after miss");
        wv = 1'b1; wa = 16'h123f; cyc("R9 wake edge");
        wv = 1'b0; cyc("R9 granted after wake");
        park = 2'b10; wv = 1'b1; wa = 16'h1200; cyc("R9 park beats wake");
        park = 2'b00; wv = 1'b0; cyc("R9 park won stays asleep");
        wv = 1'b1; wa = 16'h1200; cyc("R9 wake");
        wv = 1'b0; req = 2'b11; r0 = 6'd32; r1 = 6'd32; cyc("R2 after wake");
        r0 = 6'd0; r1 = 6'd0;

        // R2: mixed sweep of every input
        pa0 = 16'h2040;
        for (int i = 0; i < 4000; i++) begin
            int v;
            v = rnd();
            act  = ((v & 7) == 0) ? 2'(v >> 3) : 2'b11;
            req  = 2'(v >> 5);
            r0   = 6'((v >> 7) % 3);
            r1   = 6'((v >> 9) % 3);
            b0   = 5'(((v >> 11) & 7) - 4);
            b1   = 5'(((v >> 14) & 7) - 4);
            park = ((v >> 17 & 31) == 0) ? 2'(v >> 22) : 2'b00;
            wv   = (v >> 24 & 3) == 0;
            wa   = (v >> 26 & 1) ? 16'h2000 + 16'(v >> 27) : 16'h1200 + 16'(v >> 27);
            cyc("R2 sweep");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule